// File: doc/BRIEF.md
# Four-Slot Successive-Approximation Scan Controller

This controller drives an 8-bit successive-approximation converter. It does not contain the converter itself. A start strobe launches a scan of four input channels. Each channel gets a fixed-length slot of bus-clock cycles. A slot opens with a sampling window, then finds the code one bit at a time from the most significant bit down, then spends a short transfer phase storing the code.

The four codes go into four result bytes, in channel order. A completion flag rises once the whole scan is finished. In single mode the controller goes idle after one scan. In continuous mode it keeps scanning and overwrites the results each time.

The caller supplies four things:
- a clock enable at the bus-clock rate;
- a bit that picks the lower or upper group of four channels;
- a mode bit;
- the comparator decision, which is high when the sampled input is at or above the trial code.

Every timing count below is in enabled cycles, meaning rising clock edges with `clk_en` high.

Top module: `sar_seq4`

## Requirements
- R1: After reset, `sample_en`, `trial_code`, `chan_sel`, `result` and `done_flag` are all zero, and the block stays idle until `start` is pulsed.
- R2: The first 12 enabled cycles of every 32-cycle slot form the sampling window. During these cycles `sample_en` is 1 and `trial_code` is 0. In all other cycles `sample_en` is 0.
- R3: Slot cycles 12..27 resolve the bits in order 7 down to 0, two cycles per bit. During both cycles of bit b, `trial_code` equals the bits already decided, with bit b set to 1 and the lower bits at 0. At slot cycle 12 this gives 8'h80.
- R4: On the second cycle of each bit, the bit keeps the value 1 if `cmp_hi` is 1 and becomes 0 if `cmp_hi` is 0. With an ideal comparator, the stored code therefore equals the input value, including the values 0 and 255.
- R5: Slot k (k = 0..3) writes its code into `result[8k+7:8k]` on the enabled edge that ends slot cycle 28. No result byte changes during a sampling window.
- R6: `done_flag` is still 0 after 127 enabled cycles following `start`. It is 1 after the 128th, which is the last cycle of slot 3. It never rises at the end of slots 0, 1 or 2.
- R7: If `cont_mode` is 0 when slot 3 ends, the block goes idle. `sample_en` stays 0, the results hold their values, and `done_flag` stays 1.
- R8: If `cont_mode` is 1 when slot 3 ends, the scan restarts at slot 0. `done_flag` stays 1 and the result bytes are overwritten with new codes in the same order.
- R9: A `start` pulse acts on any clock edge, whether or not `clk_en` is high. It clears `done_flag`, discards any scan in progress, and restarts at slot 0, cycle 0. It does not change the result bytes.
- R10: `chan_sel` equals {group, slot}. Here group is the value of `grp_sel` captured at `start` (0 selects channels 0..3, 1 selects channels 4..7), and slot is the index of the current slot.
- R11: On a clock edge with `clk_en` low and no `start`, no internal state changes, so every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Bus-clock enable; each high cycle advances the scan by one step |
| start | input | 1 | Restart strobe (a control write) |
| cont_mode | input | 1 | 1 = repeat scans, 0 = stop after one scan |
| grp_sel | input | 1 | Channel group select, captured at start |
| cmp_hi | input | 1 | Comparator output: input is at or above the trial code |
| sample_en | output | 1 | Sample switch enable |
| chan_sel | output | 3 | Channel being converted |
| trial_code | output | 8 | Code presented to the DAC |
| result | output | 32 | Four result bytes; byte k belongs to slot k |
| done_flag | output | 1 | Set when a scan of four slots is complete |

## Verification
The bench drives `cmp_hi` from an ideal comparison against an input value held for each channel. It includes the extreme values 0 and 255, which catch a decision test that is inverted or strict, because such a design stores a code off by one step or saturates the wrong way.

The bench checks the completion flag exactly at enabled cycles 127 and 128. A design that raises the flag after an earlier slot, or one cycle off, fails there.

Two further cases are covered:
- An abort in the middle of a scan, and an abort after completion. A design that does not reset the slot or clear the flag shows a wrong channel or a stale flag.
- Runs with a gated `clk_en`. A design that advances on ungated edges changes `trial_code` while the enable is low, and finishes too early.

// File: rtl/sar_seq4.sv
module sar_seq4 #(
  parameter int DW         = 8,
  parameter int SAMPLE_CYC = 12,
  parameter int BIT_CYC    = 2,
  parameter int END_CYC    = 4,
  parameter int NCH        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              start,
  input  logic              cont_mode,
  input  logic              grp_sel,
  input  logic              cmp_hi,
  output logic              sample_en,
  output logic [$clog2(NCH):0] chan_sel,
  output logic [DW-1:0]     trial_code,
  output logic [NCH*DW-1:0] result,
  output logic              done_flag
);
  localparam int SLOT_CYC  = SAMPLE_CYC + DW*BIT_CYC + END_CYC;
  localparam int BITS_END  = SAMPLE_CYC + DW*BIT_CYC;
  localparam int CW        = $clog2(SLOT_CYC);
  localparam int SW        = $clog2(NCH);
  localparam int IW        = $clog2(DW);

  logic          run, grp_q;
  logic [CW-1:0] cyc, bit_off;
  logic [SW-1:0] slot;
  logic [DW-1:0] sar, mask;
  logic [IW-1:0] bit_idx;
  logic          in_bits, last_of_bit, slot_end, seq_end, latch_now;

  assign in_bits     = run && cyc >= CW'(SAMPLE_CYC) && cyc < CW'(BITS_END);
  assign bit_off     = cyc - CW'(SAMPLE_CYC);
  assign bit_idx     = IW'(DW-1) - IW'(bit_off / CW'(BIT_CYC));
  assign last_of_bit = (bit_off % CW'(BIT_CYC)) == CW'(BIT_CYC-1);
  assign mask        = in_bits ? (DW'(1) << bit_idx) : '0;
  assign slot_end    = cyc == CW'(SLOT_CYC-1);
  assign seq_end     = slot_end && slot == SW'(NCH-1);
  assign latch_now   = cyc == CW'(BITS_END);

  assign sample_en  = run && cyc < CW'(SAMPLE_CYC);
  assign trial_code = in_bits ? (sar | mask) : '0;
  assign chan_sel   = {grp_q, slot};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      grp_q     <= 1'b0;
      cyc       <= '0;
      slot      <= '0;
      sar       <= '0;
      result    <= '0;
      done_flag <= 1'b0;
    end else if (start) begin
      run       <= 1'b1;
      grp_q     <= grp_sel;
      cyc       <= '0;
      slot      <= '0;
      sar       <= '0;
      done_flag <= 1'b0;
    end else if (clk_en && run) begin
      if (in_bits && last_of_bit)
        sar[bit_idx] <= cmp_hi;
      if (latch_now)
        result[slot*DW +: DW] <= sar;
      if (slot_end) begin
        cyc  <= '0;
        sar  <= '0;
        slot <= seq_end ? '0 : slot + SW'(1);
        if (seq_end) begin
          done_flag <= 1'b1;
          run       <= cont_mode;
        end
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sar_seq4_chk.sv
module sar_seq4_chk #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              start,
  input logic              sample_en,
  input logic [$clog2(NCH):0] chan_sel,
  input logic [DW-1:0]     trial_code,
  input logic [NCH*DW-1:0] result,
  input logic              done_flag
);
  localparam int SW = $clog2(NCH);

  AST_SAMPLE_NO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> trial_code == '0); // R2

  AST_RESULT_HOLD_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> $stable(result)); // R5

  AST_DONE_AFTER_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(chan_sel[SW-1:0]) == SW'(NCH-1)); // R6

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_flag && chan_sel[SW-1:0] == '0); // R9

  AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !start) |=> $stable(trial_code) && $stable(sample_en)
      && $stable(chan_sel) && $stable(result) && $stable(done_flag)); // R11
endmodule

bind sar_seq4 sar_seq4_chk #(.DW(DW), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
  .sample_en(sample_en), .chan_sel(chan_sel), .trial_code(trial_code),
  .result(result), .done_flag(done_flag)
);

// File: tb/sar_seq4_tb_top.sv
module sar_seq4_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, clk_en = 1'b1, start = 1'b0, cont_mode = 1'b0, grp_sel = 1'b0;
  logic cmp_hi;
  logic sample_en, done_flag;
  logic [2:0] chan_sel;
  logic [7:0] trial_code;
  logic [31:0] result;
  logic [7:0] vin [8];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp_hi = vin[chan_sel] >= trial_code;

  sar_seq4 dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
    .cont_mode(cont_mode), .grp_sel(grp_sel), .cmp_hi(cmp_hi),
    .sample_en(sample_en), .chan_sel(chan_sel), .trial_code(trial_code),
    .result(result), .done_flag(done_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input bit grp);
    grp_sel = grp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic set_vin(input int base, input int a, input int b, input int c, input int d);
    vin[base] = 8'(a); vin[base+1] = 8'(b); vin[base+2] = 8'(c); vin[base+3] = 8'(d);
  endtask

  task automatic check_results(input int base, input string tag);
    for (int k = 0; k < 4; k++)
      chk(result[k*8 +: 8] == vin[base+k], tag, result[k*8 +: 8], vin[base+k]);
  endtask

  task automatic t_reset();
    chk(sample_en == 0 && trial_code == 0 && chan_sel == 0, "R1 outputs idle", {sample_en, trial_code}, 0);
    chk(result == 0 && done_flag == 0, "R1 results/flag", result, 0);
    repeat (5) @(negedge clk);
    chk(sample_en == 0 && done_flag == 0, "R1 stays idle", sample_en, 0);
  endtask

  task automatic t_single(input bit grp);
    int base = grp ? 4 : 0;
    cont_mode = 1'b0;
    pulse_start(grp);
    for (int k = 0; k < 128; k++) begin
      int s = k % 32;
      int sl = k / 32;
      chk(sample_en == (s < 12), "R2 sample window", sample_en, s < 12);
      if (s < 12) chk(trial_code == 0, "R2 trial zero while sampling", trial_code, 0);
      if (s == 12) chk(trial_code == 8'h80, "R3 msb trial", trial_code, 8'h80);
      if (s == 13) chk(trial_code == 8'h80, "R3 msb held two cycles", trial_code, 8'h80);
      if (s == 14) chk(trial_code == ((vin[base+sl] & 8'h80) | 8'h40), "R3 bit6 trial",
                       trial_code, (vin[base+sl] & 8'h80) | 8'h40);
      if (s == 0) chk(chan_sel == 3'(base + sl), "R10 channel", chan_sel, base + sl);
      if (s == 29) chk(result[sl*8 +: 8] == vin[base+sl], "R5 result latched", result[sl*8 +: 8], vin[base+sl]);
      if (k == 127 || s == 31) chk(done_flag == 0, "R6 flag not early", done_flag, 0);
      @(negedge clk);
    end
    chk(done_flag == 1, "R6 flag after fourth slot", done_flag, 1);
    check_results(base, "R4 codes match inputs");
    repeat (40) begin
      @(negedge clk);
      chk(sample_en == 0 && done_flag == 1, "R7 idle after single scan", sample_en, 0);
    end
    check_results(base, "R7 results held");
  endtask

  task automatic t_cont();
    set_vin(0, 8'h33, 8'h01, 8'hFE, 8'h99);
    cont_mode = 1'b1;
    pulse_start(1'b0);
    repeat (128) @(negedge clk);
    chk(done_flag == 1, "R8 flag after first scan", done_flag, 1);
    check_results(0, "R8 first scan results");
    set_vin(0, 8'h44, 8'hC3, 8'h0F, 8'h00);
    chk(sample_en == 1 && chan_sel == 0, "R8 scan restarts", chan_sel, 0);
    repeat (100) @(negedge clk);
    chk(done_flag == 1, "R8 flag stays during rescan", done_flag, 1);
    cont_mode = 1'b0;
    repeat (28) @(negedge clk);
    check_results(0, "R8 results overwritten");
    repeat (10) @(negedge clk);
    chk(sample_en == 0, "R7 stops when mode cleared", sample_en, 0);
  endtask

  task automatic t_abort();
    set_vin(4, 8'h10, 8'h20, 8'h30, 8'h40);
    cont_mode = 1'b0;
    pulse_start(1'b0);
    repeat (50) @(negedge clk);
    chk(chan_sel == 3'd1, "R10 slot one mid-scan", chan_sel, 1);
    pulse_start(1'b1);
    chk(chan_sel == 3'd4 && sample_en == 1 && done_flag == 0, "R9 abort restarts", chan_sel, 4);
    repeat (127) @(negedge clk);
    chk(done_flag == 0, "R9 full scan after abort", done_flag, 0);
    @(negedge clk);
    chk(done_flag == 1, "R9 flag after restarted scan", done_flag, 1);
    check_results(4, "R9 upper group results");
    clk_en = 1'b0;
    pulse_start(1'b0);
    chk(done_flag == 0 && chan_sel == 0, "R9 start clears flag with enable low", done_flag, 0);
    check_results(4, "R9 results kept on start");
    clk_en = 1'b1;
    repeat (128) @(negedge clk);
  endtask

  task automatic t_gated();
    logic [7:0] tc; logic se; logic [2:0] cs;
    set_vin(0, 8'h00, 8'hFF, 8'h80, 8'h7F);
    cont_mode = 1'b0;
    clk_en = 1'b0;
    pulse_start(1'b0);
    for (int k = 0; k < 128; k++) begin
      tc = trial_code; se = sample_en; cs = chan_sel;
      clk_en = 1'b0;
      @(negedge clk);
      if (k % 8 == 5)
        chk(trial_code == tc && sample_en == se && chan_sel == cs, "R11 frozen while gated", trial_code, tc);
      clk_en = 1'b1;
      @(negedge clk);
      if (k == 126) chk(done_flag == 0, "R11 no early finish", done_flag, 0);
    end
    clk_en = 1'b1;
    chk(done_flag == 1, "R11 finish after 128 enabled cycles", done_flag, 1);
    check_results(0, "R4 extreme codes");
  endtask

  initial begin
    set_vin(0, 8'h5A, 8'hA5, 8'h00, 8'hFF);
    set_vin(4, 8'h01, 8'h80, 8'h7F, 8'hC3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(1'b0);
    t_single(1'b1);
    t_cont();
    t_abort();
    t_gated();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule